// File: doc/BRIEF.md
# Dual-Chain Carry-Select Adder/Subtractor Slice

This block is a 10-bit arithmetic slice. Every bit position computes its sum and carry-out twice, once assuming the carry arriving at its group is 0 and once assuming it is 1. The two results travel up two parallel carry chains. The slice is cut into two 5-bit groups. At the top of each group, the real carry entering that group picks one of the two chains. The carry leaving the group is rebuilt there and becomes the carry entering the next group. As a result, only the per-group selects lie on the long carry path.

A dynamic subtract control turns the slice into a subtractor. It inverts every B bit and forces the carry into the least significant bit to 1.

The same adder also drives an output register, which can be used as an accumulator or as an up/down counter. The register has a synchronous clear and a synchronous load, and a step enable that advances it. A two-bit mode input selects what the outputs show:
- In the combinational modes, the sum and carry come straight from the adder.
- In the registered modes, the sum and carry come from the register.

Top module: `csel_arith_slice`

## Requirements
- R1: While reset is held low, the register value and the registered carry are 0, so in a registered mode sum_out and carry_out read 0.
- R2: With mode 0 or mode 3 (combinational) and sub_mode=0, {carry_out,sum_out} equals op_a+op_b+cin in the same cycle, with no clock edge needed.
- R3: In a combinational mode with sub_mode=1, sum_out equals (op_a-op_b) mod 1024. cin is ignored. carry_out is 1 exactly when op_a>=op_b, which means no borrow.
- R4: A carry leaving the low group (bits 0..4) reaches the high group (bits 5..9). For example, 0x01F+0x001 gives 0x020, and a carry out of bit 9 shows as carry_out=1.
- R5: In mode 1 (accumulate), each rising edge with step_en=1 replaces the register with register±op_b, following the R2/R3 rules for sub_mode and cin, and stores the carry-out. sum_out and carry_out show the stored values.
- R6: In mode 2 (count), each rising edge with step_en=1 adds 1 when up_dn=1 or subtracts 1 when up_dn=0, ignoring op_b, sub_mode and cin. The stored carry is 1 on an up-wrap from 0x3FF, and 0 on a down-step from 0x000, which is a borrow. Otherwise an up-step stores 0 and a down-step stores 1.
- R7: In modes 1 and 2 with step_en=0 and no clear or load, the register and the stored carry keep their values.
- R8: sync_ld=1 with sync_clr=0 loads op_a into the register and clears the stored carry in any mode. A load takes priority over a step.
- R9: sync_clr=1 zeros the register and the stored carry in any mode. A clear takes priority over both a load and a step.
- R10: In a combinational mode, step_en has no effect on the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode | input | 2 | 0/3 combinational, 1 accumulate, 2 count |
| op_a | input | 10 | Operand A; also the load value |
| op_b | input | 10 | Operand B |
| sub_mode | input | 1 | 1 selects A-B (combinational and accumulate modes) |
| cin | input | 1 | Carry into bit 0 when adding |
| step_en | input | 1 | Advances the register in modes 1 and 2 |
| up_dn | input | 1 | Count direction, 1 is up |
| sync_clr | input | 1 | Synchronous clear of the register |
| sync_ld | input | 1 | Synchronous load of op_a |
| sum_out | output | 10 | Sum, either from the adder or from the register |
| carry_out | output | 1 | Final carry, either from the adder or stored |

## Verification
Clear, load and step can all be requested on the same rising edge, and their priority decides the register value. The bench raises sync_clr, sync_ld and step_en together and expects zero. It then raises sync_ld and step_en together in count mode and expects exactly the loaded operand, not the operand plus one. A separate run steps the register while a combinational mode is selected. It then switches to accumulate mode with stepping disabled and checks that the old value is still there.

// File: rtl/csel_pkg.sv
package csel_pkg;

  typedef enum logic [1:0] {
    MODE_COMB     = 2'b00,
    MODE_ACC      = 2'b01,
    MODE_CNT      = 2'b10,
    MODE_COMB_ALT = 2'b11
  } slice_mode_e;

endpackage

// File: rtl/csel_cell.sv
// One bit position: sum and carry for both assumed group carries.
module csel_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic ci0_i,
  input  logic ci1_i,
  output logic s0_o,
  output logic s1_o,
  output logic co0_o,
  output logic co1_o
);

  logic half;

  assign half  = a_i ^ b_i;
  assign s0_o  = half ^ ci0_i;
  assign s1_o  = half ^ ci1_i;
  assign co0_o = (a_i & b_i) | (half & ci0_i);
  assign co1_o = (a_i & b_i) | (half & ci1_i);

endmodule

// File: rtl/csel_group.sv
// A group of GRP_W cells with two precomputed chains; the real group
// carry-in chooses one chain at the group's top bit.
module csel_group #(
  parameter int GRP_W = 5
) (
  input  logic [GRP_W-1:0] a_i,
  input  logic [GRP_W-1:0] b_i,
  input  logic             gcin_i,
  output logic [GRP_W-1:0] sum_o,
  output logic             gcout_o
);

  logic [GRP_W:0]   chain0;
  logic [GRP_W:0]   chain1;
  logic [GRP_W-1:0] sum0;
  logic [GRP_W-1:0] sum1;

  assign chain0[0] = 1'b0;
  assign chain1[0] = 1'b1;

  for (genvar i = 0; i < GRP_W; i++) begin : g_bit
    csel_cell i_cell (
      .a_i   (a_i[i]),
      .b_i   (b_i[i]),
      .ci0_i (chain0[i]),
      .ci1_i (chain1[i]),
      .s0_o  (sum0[i]),
      .s1_o  (sum1[i]),
      .co0_o (chain0[i+1]),
      .co1_o (chain1[i+1])
    );
  end

  assign sum_o   = gcin_i ? sum1 : sum0;
  assign gcout_o = gcin_i ? chain1[GRP_W] : chain0[GRP_W];

endmodule

// File: rtl/csel_acc_reg.sv
// Output register: clear beats load beats step.
module csel_acc_reg #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         ld_i,
  input  logic         step_i,
  input  logic [W-1:0] ld_val_i,
  input  logic [W-1:0] nxt_val_i,
  input  logic         nxt_carry_i,
  output logic [W-1:0] q_o,
  output logic         c_o
);

  logic         reg_en;
  logic [W-1:0] q_d;
  logic         c_d;

  always_comb begin
    reg_en = clr_i | ld_i | step_i;
    q_d    = q_o;
    c_d    = c_o;
    if (clr_i) begin
      q_d = '0;
      c_d = 1'b0;
    end else if (ld_i) begin
      q_d = ld_val_i;
      c_d = 1'b0;
    end else if (step_i) begin
      q_d = nxt_val_i;
      c_d = nxt_carry_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o <= '0;
      c_o <= 1'b0;
    end else if (reg_en) begin
      q_o <= q_d;
      c_o <= c_d;
    end
  end

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (q_o == '0) && !c_o); // R9
  AST_LOAD_VAL: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && ld_i) |=> (q_o == $past(ld_val_i)) && !c_o); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !ld_i && !step_i) |=> $stable(q_o) && $stable(c_o)); // R7

endmodule

// File: rtl/csel_arith_slice.sv
module csel_arith_slice
  import csel_pkg::*;
#(
  parameter int GRP_W = 5,
  parameter int N_GRP = 2,
  localparam int W    = GRP_W * N_GRP
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         sub_mode,
  input  logic         cin,
  input  logic         step_en,
  input  logic         up_dn,
  input  logic         sync_clr,
  input  logic         sync_ld,
  output logic [W-1:0] sum_out,
  output logic         carry_out
);

  slice_mode_e  md;
  logic         reg_mode;
  logic [W-1:0] a_sel;
  logic [W-1:0] b_sel;
  logic         sub_sel;
  logic         cin_sel;
  logic [W-1:0] b_eff;
  logic         cin_eff;
  logic [W-1:0] add_sum;
  logic [N_GRP:0] gcarry;
  logic [W-1:0] acc_q;
  logic         acc_c;
  logic         step_q;

  assign md       = slice_mode_e'(mode);
  assign reg_mode = (md == MODE_ACC) || (md == MODE_CNT);

  // Operand steering per mode
  always_comb begin
    case (md)
      MODE_ACC: begin
        a_sel   = acc_q;
        b_sel   = op_b;
        sub_sel = sub_mode;
        cin_sel = cin;
      end
      MODE_CNT: begin
        a_sel   = acc_q;
        b_sel   = W'(1);
        sub_sel = ~up_dn;
        cin_sel = 1'b0;
      end
      default: begin
        a_sel   = op_a;
        b_sel   = op_b;
        sub_sel = sub_mode;
        cin_sel = cin;
      end
    endcase
  end

  // Subtraction: invert B, force carry into bit 0
  assign b_eff     = b_sel ^ {W{sub_sel}};
  assign cin_eff   = sub_sel | cin_sel;
  assign gcarry[0] = cin_eff;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    csel_group #(.GRP_W(GRP_W)) i_grp (
      .a_i     (a_sel[g*GRP_W +: GRP_W]),
      .b_i     (b_eff[g*GRP_W +: GRP_W]),
      .gcin_i  (gcarry[g]),
      .sum_o   (add_sum[g*GRP_W +: GRP_W]),
      .gcout_o (gcarry[g+1])
    );
  end

  assign step_q = step_en & reg_mode;

  csel_acc_reg #(.W(W)) i_acc (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (sync_clr),
    .ld_i        (sync_ld),
    .step_i      (step_q),
    .ld_val_i    (op_a),
    .nxt_val_i   (add_sum),
    .nxt_carry_i (gcarry[N_GRP]),
    .q_o         (acc_q),
    .c_o         (acc_c)
  );

  assign sum_out   = reg_mode ? acc_q : add_sum;
  assign carry_out = reg_mode ? acc_c : gcarry[N_GRP];

  AST_COMB_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_mode && !sub_mode) |->
      ({carry_out, sum_out} == ({1'b0, op_a} + {1'b0, op_b} + (W+1)'(cin)))); // R2
  AST_COMB_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_mode && sub_mode) |->
      ((sum_out == W'(op_a - op_b)) && (carry_out == (op_a >= op_b)))); // R3
  AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ((md == MODE_ACC) && step_en && !sync_clr && !sync_ld) |=>
      ({acc_c, acc_q} == $past(sub_mode ?
        ({1'b0, acc_q} + {1'b0, ~op_b} + (W+1)'(1)) :
        ({1'b0, acc_q} + {1'b0, op_b} + (W+1)'(cin))))); // R5
  AST_CNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    ((md == MODE_CNT) && step_en && up_dn && !sync_clr && !sync_ld) |=>
      (acc_q == W'($past(acc_q) + W'(1)))); // R6
  AST_COMB_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_mode && !sync_clr && !sync_ld) |=> $stable(acc_q)); // R10

endmodule

// File: tb/test_csel_arith_slice.sv
module test_csel_arith_slice;

  localparam int PERIOD = 10;
  localparam int W      = 10;
  localparam int NVEC   = 12;

  // {sub, cin, a, b, exp_carry, exp_sum}
  localparam logic [32:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 10'h000, 10'h000, 1'b0, 10'h000},
    {1'b0, 1'b1, 10'h3FF, 10'h000, 1'b1, 10'h000},
    {1'b0, 1'b0, 10'h01F, 10'h001, 1'b0, 10'h020}, // R4 low group carry
    {1'b0, 1'b0, 10'h200, 10'h200, 1'b1, 10'h000},
    {1'b0, 1'b1, 10'h155, 10'h2AA, 1'b1, 10'h000},
    {1'b0, 1'b0, 10'h123, 10'h045, 1'b0, 10'h168},
    {1'b1, 1'b0, 10'h200, 10'h001, 1'b1, 10'h1FF},
    {1'b1, 1'b1, 10'h000, 10'h001, 1'b0, 10'h3FF},
    {1'b1, 1'b0, 10'h3FF, 10'h3FF, 1'b1, 10'h000},
    {1'b1, 1'b1, 10'h005, 10'h00A, 1'b0, 10'h3FB},
    {1'b0, 1'b0, 10'h3E0, 10'h020, 1'b1, 10'h000},
    {1'b0, 1'b1, 10'h01F, 10'h000, 1'b0, 10'h020}  // R4 carry-in through low group
  };

  logic         clk;
  logic         rst_n;
  logic [1:0]   mode;
  logic [W-1:0] op_a;
  logic [W-1:0] op_b;
  logic         sub_mode;
  logic         cin;
  logic         step_en;
  logic         up_dn;
  logic         sync_clr;
  logic         sync_ld;
  logic [W-1:0] sum_out;
  logic         carry_out;

  int n_chk;
  int n_fail;

  csel_arith_slice i_csel_arith_slice (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .op_a      (op_a),
    .op_b      (op_b),
    .sub_mode  (sub_mode),
    .cin       (cin),
    .step_en   (step_en),
    .up_dn     (up_dn),
    .sync_clr  (sync_clr),
    .sync_ld   (sync_ld),
    .sum_out   (sum_out),
    .carry_out (carry_out)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [W:0] exp);
    n_chk++;
    if ({carry_out, sum_out} !== exp) begin
      n_fail++;
      $display("FAIL %s: actual carry=%b sum=%h expected carry=%b sum=%h",
               tag, carry_out, sum_out, exp[W], exp[W-1:0]);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [W:0] model(input logic s, input logic c,
                                       input logic [W-1:0] a,
                                       input logic [W-1:0] b);
    if (s) return {1'b0, a} + {1'b0, ~b} + (W+1)'(1);
    return {1'b0, a} + {1'b0, b} + (W+1)'(c);
  endfunction

  initial begin
    #(PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b0;
    mode = 2'd1;
    op_a = '0; op_b = '0; sub_mode = 1'b0; cin = 1'b0;
    step_en = 1'b0; up_dn = 1'b1; sync_clr = 1'b0; sync_ld = 1'b0;
    #(PERIOD * 2 + 1);
    chk("R1 reset value", 11'h000);
    @(negedge clk);
    rst_n = 1'b1;
    mode = 2'd0;

    // Table walk, combinational mode
    for (int i = 0; i < NVEC; i++) begin
      {sub_mode, cin, op_a, op_b} = VEC[i][32:11];
      #1;
      chk(VEC[i][32] ? "R3 table" : "R2/R4 table", VEC[i][10:0]);
      @(negedge clk);
    end

    // Random operands against the behavioural model
    for (int i = 0; i < 40; i++) begin
      op_a = W'($urandom);
      op_b = W'($urandom);
      sub_mode = 1'($urandom);
      cin = 1'($urandom);
      #1;
      chk(sub_mode ? "R3 random" : "R2 random", model(sub_mode, cin, op_a, op_b));
      @(negedge clk);
    end

    // Mode 3 also combinational
    mode = 2'd3; op_a = 10'h2AA; op_b = 10'h0AA; sub_mode = 1'b1; cin = 1'b0;
    #1;
    chk("R2 mode3 sub", 11'h600);
    @(negedge clk);

    // Registered modes
    mode = 2'd1; sync_ld = 1'b1; step_en = 1'b1; op_a = 10'h3F0; sub_mode = 1'b0;
    tick; chk("R8 load over step", 11'h3F0);
    sync_ld = 1'b0; op_b = 10'h00F; cin = 1'b1;
    tick; chk("R5 accumulate add", 11'h400);
    sub_mode = 1'b1; op_b = 10'h001; cin = 1'b0;
    tick; chk("R5 accumulate sub", 11'h3FF);
    step_en = 1'b0; op_b = 10'h123;
    tick; chk("R7 hold accumulate", 11'h3FF);
    mode = 2'd2; step_en = 1'b1; up_dn = 1'b1; sub_mode = 1'b1; cin = 1'b1; op_b = 10'h0F0;
    tick; chk("R6 count up wrap", 11'h400);
    tick; chk("R6 count up", 11'h001);
    up_dn = 1'b0;
    tick; chk("R6 count down", 11'h400);
    tick; chk("R6 count down borrow", 11'h3FF);
    step_en = 1'b0;
    tick; chk("R7 hold count", 11'h3FF);
    sync_clr = 1'b1; sync_ld = 1'b1; step_en = 1'b1; op_a = 10'h155;
    tick; chk("R9 clear wins", 11'h000);
    sync_clr = 1'b0; up_dn = 1'b1;
    tick; chk("R8 load over count", 11'h155);
    sync_ld = 1'b0; mode = 2'd0; step_en = 1'b1; sub_mode = 1'b0;
    op_a = 10'h001; op_b = 10'h001; cin = 1'b0;
    tick; tick; tick;
    mode = 2'd1; step_en = 1'b0;
    #1;
    chk("R10 no step in comb mode", 11'h155);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule